// File: doc/BRIEF.md
# SPI Register Access Port

This block is an SPI slave that lets a host microcontroller read and write a bank of 32 byte-wide registers that sit outside the block. The serial clock, chip select and serial data input are brought into the system clock domain through two-flop synchronisers. Serial clock edges are then detected in that domain, so the block runs entirely on `clk`. A transfer opens when chip select falls. The first byte is a command that holds a 5-bit register address, a direction bit and an acknowledge-status bit. Each further group of eight serial clocks moves one data byte, and the transfer ends when chip select rises again.

Written bytes leave the block on a one-cycle write strobe that carries an address and the data. Read bytes are fetched through a read strobe and address. The register file answers on `rd_data` one clock after the strobe. The address advances by one after each data byte while it lies inside a window of control registers (5 to 20 by default). Outside that window it stays fixed, so a FIFO data register can be streamed. A duplex input picks between separate in and out data pins and a half-duplex mode in which read data is driven back on the input data pin.

Top module: `spi_regport`

## Requirements
- R1: Command byte layout: bits 7:3 are the register address, bit 1 is the direction (1 = write, 0 = read), bit 0 is the acknowledge-status flag, and bit 2 has no effect.
- R2: `ack_flag` takes the value of command bit 0 once each command byte is complete and holds it until the next command byte.
- R3: In a write transfer, every complete data byte produces exactly one single-cycle `wr_strobe` with `wr_addr` and `wr_data`.
- R4: In a read transfer, `rd_strobe` pulses once when the command byte completes and once after each complete data byte (prefetch of the next byte). The fetched byte is shifted out MSB first, and each bit is valid at the serial clock rising edge that samples it.
- R5: After each data byte, an address inside the window AINC_LO..AINC_HI (5..20) advances by one. Address 20 advances to 21.
- R6: After each data byte, an address outside the window stays the same.
- R7: A byte cut short by chip select rising causes no write, and this includes the case where chip select rises in the same cycle as the eighth rising edge.
- R8: With `full_duplex` = 1, `miso_oe` is 1 while chip select is low and `mosi_oe` is 0.
- R9: With `full_duplex` = 0, `miso_oe` is 0. `mosi_oe` is 1 only during the data bytes of a read transfer while chip select is low, and the read data appears on `mosi_o`.
- R10: Data is sampled on rising serial clock edges, so the port works unchanged with an idle-low clock (mode 0) and an idle-high clock (mode 3).
- R11: Chip select high returns the port to the command phase, stops the data drivers and strobes, and the next transfer decodes its first byte as a command. Read and write strobes never fire together.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI serial clock (asynchronous) |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| full_duplex | input | 1 | 1: separate data pins, 0: shared data pin |
| miso_o | output | 1 | Serial read data, full-duplex pin |
| miso_oe | output | 1 | Output enable for `miso_o` |
| mosi_o | output | 1 | Serial read data driven on the shared pin |
| mosi_oe | output | 1 | Output enable for `mosi_o` |
| rd_strobe | output | 1 | Register read request, one cycle |
| rd_addr | output | 5 | Register read address |
| rd_data | input | 8 | Register read data, valid one cycle after `rd_strobe` |
| wr_strobe | output | 1 | Register write strobe, one cycle |
| wr_addr | output | 5 | Register write address |
| wr_data | output | 8 | Register write data |
| ack_flag | output | 1 | Latched acknowledge-status bit from the last command |

## Verification
Two events can land in the same system clock cycle: the detected rising edge that completes a byte and the synchronised rise of chip select. The bench provokes this by sending seven bits of a data byte and then raising the serial clock and chip select at the same instant. It judges the outcome by the write count, which must not change, and then by a fresh transfer that must decode cleanly as a command. It also sends a byte cut short after four bits to confirm the same discard away from the boundary.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              spare;
    logic              wr;
    logic              ack;
  } cmd_t;

  function automatic logic [ADDR_W-1:0] bump_addr(
      input logic [ADDR_W-1:0] a,
      input logic [ADDR_W-1:0] lo,
      input logic [ADDR_W-1:0] hi);
    return (a >= lo && a <= hi) ? a + 1'b1 : a;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              dout
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BMAX = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_sr[DATA_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      bitcnt    <= '0;
      rx_sr     <= '0;
      byte_done <= 1'b0;
      if (rst) rx_byte <= '0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        rx_sr  <= rx_next;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == BMAX) begin
          byte_done <= 1'b1;
          rx_byte   <= rx_next;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      dout  <= 1'b0;
    end else if (load) begin
      tx_sr <= load_data;
    end else if (!active) begin
      dout <= 1'b0;
    end else if (fall) begin
      dout  <= tx_sr[DATA_W-1];
      tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_cmd_ctl.sv
module spi_cmd_ctl
  import spi_regport_pkg::*;
#(
  parameter int unsigned AINC_LO = 5,
  parameter int unsigned AINC_HI = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              rd_strobe,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ack_flag,
  output logic              rd_phase
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(AINC_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(AINC_HI);

  phase_t            phase;
  logic              is_wr;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] nxt;
  cmd_t              cmd;

  assign cmd      = cmd_t'(rx_byte);
  assign nxt      = bump_addr(addr, LO, HI);
  assign rd_phase = (phase == PH_DATA) && !is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      is_wr     <= 1'b0;
      addr      <= '0;
      ack_flag  <= 1'b0;
      rd_strobe <= 1'b0;
      rd_addr   <= '0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      rd_strobe <= 1'b0;
      wr_strobe <= 1'b0;
      if (!active) begin
        phase <= PH_CMD;
        is_wr <= 1'b0;
      end else if (byte_done) begin
        if (phase == PH_CMD) begin
          phase    <= PH_DATA;
          addr     <= cmd.addr;
          is_wr    <= cmd.wr;
          ack_flag <= cmd.ack;
          if (!cmd.wr) begin
            rd_strobe <= 1'b1;
            rd_addr   <= cmd.addr;
          end
        end else begin
          addr <= nxt;
          if (is_wr) begin
            wr_strobe <= 1'b1;
            wr_addr   <= addr;
            wr_data   <= rx_byte;
          end else begin
            rd_strobe <= 1'b1;
            rd_addr   <= nxt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int unsigned AINC_LO = 5,
  parameter int unsigned AINC_HI = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic              full_duplex,
  output logic              miso_o,
  output logic              miso_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  output logic              rd_strobe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ack_flag
);
  logic [2:0] pins_s;
  logic       sck_s, csn_s, mosi_s, sck_d;
  logic       active, rise, fall;
  logic       byte_done, dout, rd_phase, load_q;
  logic [DATA_W-1:0] rx_byte;

  spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({mosi_i, csn_i, sck_i}), .q(pins_s)
  );
  assign {mosi_s, csn_s, sck_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b0;
      load_q  <= 1'b0;
      miso_oe <= 1'b0;
      mosi_oe <= 1'b0;
    end else begin
      sck_d   <= sck_s;
      load_q  <= rd_strobe;
      miso_oe <= active && full_duplex;
      mosi_oe <= active && !full_duplex && rd_phase;
    end
  end

  assign active = !csn_s;
  assign rise   = sck_s && !sck_d;
  assign fall   = !sck_s && sck_d;

  spi_byte_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .active(active), .rise(rise), .fall(fall),
    .din(mosi_s), .load(load_q), .load_data(rd_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .dout(dout)
  );

  spi_cmd_ctl #(.AINC_LO(AINC_LO), .AINC_HI(AINC_HI)) u_ctl (
    .clk(clk), .rst(rst), .active(active), .byte_done(byte_done),
    .rx_byte(rx_byte), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .ack_flag(ack_flag), .rd_phase(rd_phase)
  );

  assign miso_o = dout;
  assign mosi_o = dout;
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst,
  input logic csn_i,
  input logic full_duplex,
  input logic rd_strobe,
  input logic wr_strobe,
  input logic miso_oe,
  input logic mosi_oe
);
  p_single_wr_r3: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  p_single_rd_r4: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe);

  p_no_rdwr_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));

  p_oe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(miso_oe && mosi_oe));

  p_half_no_miso_r9: assert property (@(posedge clk) disable iff (rst)
    (!full_duplex && !$past(full_duplex)) |-> !miso_oe);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4))
      |-> (!miso_oe && !mosi_oe && !wr_strobe && !rd_strobe));
endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk(clk), .rst(rst), .csn_i(csn_i), .full_duplex(full_duplex),
  .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
  .miso_oe(miso_oe), .mosi_oe(mosi_oe)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, full_duplex = 1'b1;
  logic miso_o, miso_oe, mosi_o, mosi_oe;
  logic rd_strobe, wr_strobe, ack_flag;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [4:0] log_a [16];
  logic [7:0] log_d [16];
  logic [7:0] regs [32];
  bit mode3 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .full_duplex(full_duplex), .miso_o(miso_o), .miso_oe(miso_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_strobe(wr_strobe),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack_flag(ack_flag)
  );

  function automatic logic [7:0] fill(int i);
    return 8'(i * 13 + 7);
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = fill(i);
    rd_data = 8'h00;
  end

  always @(posedge clk) begin
    if (wr_strobe) begin
      regs[wr_addr] <= wr_data;
      if (wr_cnt < 16) begin
        log_a[wr_cnt] <= wr_addr;
        log_d[wr_cnt] <= wr_data;
      end
      wr_cnt <= wr_cnt + 1;
    end
    if (rd_strobe) begin
      rd_data <= regs[rd_addr];
      rd_cnt  <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 0; b < n; b++) begin
      if (mode3) sck = 1'b0;
      mosi = tx[7 - b];
      wait_n(HALF);
      rx = {rx[6:0], full_duplex ? miso_o : mosi_o};
      sck = 1'b1;
      wait_n(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    sck = mode3;
    wait_n(4);
    csn = 1'b0;
    wait_n(HALF);
  endtask

  task automatic cs_end();
    wait_n(HALF);
    csn = 1'b1;
    wait_n(4 * HALF);
  endtask

  task automatic t_reset();
    check(!miso_oe && !mosi_oe && !rd_strobe && !wr_strobe && !ack_flag &&
          wr_addr == 0 && wr_data == 0 && rd_addr == 0 && !miso_o && !mosi_o,
          "R12 outputs zero after reset",
          {miso_oe, mosi_oe, rd_strobe, wr_strobe, ack_flag}, 0);
  endtask

  task automatic t_write_window();
    logic [7:0] rx;
    int w0;
    mode3 = 0; full_duplex = 1;
    w0 = wr_cnt;
    cs_begin();
    spi_bits({5'd19, 1'b0, 1'b1, 1'b1}, 8, rx);
    spi_bits(8'hA1, 8, rx);
    check(miso_oe && !mosi_oe, "R8 full duplex enables", {miso_oe, mosi_oe}, 2'b10);
    spi_bits(8'hB2, 8, rx);
    spi_bits(8'hC3, 8, rx);
    cs_end();
    check(wr_cnt - w0 == 3, "R3 one write per byte", wr_cnt - w0, 3);
    check(log_a[w0] == 19 && log_d[w0] == 8'hA1, "R1 R3 first write", {log_a[w0], log_d[w0]}, {5'd19, 8'hA1});
    check(log_a[w0+1] == 20 && log_d[w0+1] == 8'hB2, "R5 increment in window", {log_a[w0+1], log_d[w0+1]}, {5'd20, 8'hB2});
    check(log_a[w0+2] == 21 && log_d[w0+2] == 8'hC3, "R5 top of window to 21", {log_a[w0+2], log_d[w0+2]}, {5'd21, 8'hC3});
    check(ack_flag == 1'b1, "R2 ack bit latched 1", ack_flag, 1);
    check(!miso_oe && !mosi_oe, "R11 drivers off after deselect", {miso_oe, mosi_oe}, 0);
  endtask

  task automatic t_write_fifo();
    logic [7:0] rx;
    int w0;
    mode3 = 1; full_duplex = 0;
    w0 = wr_cnt;
    cs_begin();
    spi_bits({5'd3, 1'b1, 1'b1, 1'b0}, 8, rx);
    spi_bits(8'h55, 8, rx);
    check(!mosi_oe && !miso_oe, "R9 no drive in half-duplex write", {miso_oe, mosi_oe}, 0);
    spi_bits(8'h66, 8, rx);
    cs_end();
    check(wr_cnt - w0 == 2, "R10 mode 3 write count", wr_cnt - w0, 2);
    check(log_a[w0] == 3 && log_d[w0] == 8'h55, "R1 spare bit ignored", {log_a[w0], log_d[w0]}, {5'd3, 8'h55});
    check(log_a[w0+1] == 3 && log_d[w0+1] == 8'h66, "R6 address repeats", {log_a[w0+1], log_d[w0+1]}, {5'd3, 8'h66});
    check(ack_flag == 1'b0, "R2 ack bit latched 0", ack_flag, 0);
  endtask

  task automatic t_read_window();
    logic [7:0] rx0, rx1, rx;
    int r0;
    mode3 = 0; full_duplex = 1;
    r0 = rd_cnt;
    cs_begin();
    spi_bits({5'd6, 1'b0, 1'b0, 1'b1}, 8, rx);
    spi_bits(8'hFF, 8, rx0);
    spi_bits(8'hFF, 8, rx1);
    check(miso_oe && !mosi_oe, "R8 miso driven in read", {miso_oe, mosi_oe}, 2'b10);
    cs_end();
    check(rx0 == fill(6), "R4 read first byte", rx0, fill(6));
    check(rx1 == fill(7), "R5 read increments", rx1, fill(7));
    check(rd_cnt - r0 == 3, "R4 read strobe count", rd_cnt - r0, 3);
    check(ack_flag == 1'b1, "R2 ack on read command", ack_flag, 1);
  endtask

  task automatic t_read_fifo();
    logic [7:0] rx0, rx1, rx;
    int r0;
    mode3 = 1; full_duplex = 0;
    r0 = rd_cnt;
    cs_begin();
    spi_bits({5'd25, 1'b0, 1'b0, 1'b0}, 8, rx);
    spi_bits(8'h00, 8, rx0);
    check(mosi_oe && !miso_oe, "R9 shared pin driven in read", {miso_oe, mosi_oe}, 2'b01);
    spi_bits(8'h00, 8, rx1);
    cs_end();
    check(rx0 == fill(25), "R10 mode 3 half-duplex read", rx0, fill(25));
    check(rx1 == fill(25), "R6 fifo read repeats", rx1, fill(25));
    check(rd_cnt - r0 == 3, "R4 strobe per byte", rd_cnt - r0, 3);
    check(!mosi_oe, "R11 shared pin released", mosi_oe, 0);
  endtask

  task automatic t_partial();
    logic [7:0] rx;
    int w0;
    mode3 = 0; full_duplex = 1;
    w0 = wr_cnt;
    cs_begin();
    spi_bits({5'd10, 1'b0, 1'b1, 1'b0}, 8, rx);
    spi_bits(8'h9C, 4, rx);
    cs_end();
    check(wr_cnt == w0, "R7 half byte discarded", wr_cnt - w0, 0);
    // Seventh bit, then clock rise and deselect together
    cs_begin();
    spi_bits({5'd10, 1'b0, 1'b1, 1'b0}, 8, rx);
    spi_bits(8'h5A, 8, rx);
    spi_bits(8'h3C, 7, rx);
    mosi = 1'b0;
    wait_n(HALF);
    sck = 1'b1;
    csn = 1'b1;
    wait_n(4 * HALF);
    sck = 1'b0;
    wait_n(HALF);
    check(wr_cnt - w0 == 1, "R7 boundary byte discarded", wr_cnt - w0, 1);
    check(log_a[w0] == 10 && log_d[w0] == 8'h5A, "R3 full byte kept", {log_a[w0], log_d[w0]}, {5'd10, 8'h5A});
    // fresh transfer decodes as command
    cs_begin();
    spi_bits({5'd12, 1'b0, 1'b1, 1'b1}, 8, rx);
    spi_bits(8'h77, 8, rx);
    cs_end();
    check(wr_cnt - w0 == 2 && log_a[w0+1] == 12 && log_d[w0+1] == 8'h77,
          "R11 new command after deselect", {log_a[w0+1], log_d[w0+1]}, {5'd12, 8'h77});
  endtask

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(5);
    t_reset();
    t_write_window();
    t_write_fifo();
    t_read_window();
    t_read_fifo();
    t_partial();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule